// File: doc/BRIEF.md
# SMBus Block-Read Target

This block is the target side of a two-wire SMBus/I2C link. It serves bytes from a fixed register bank through a block-read process call. The host first runs a setup write that names a first register and a byte length. It then reads the data back, either after a repeated START in one combined transaction or later as a separate transaction that opens with the same command. Every read opens with a length byte, and register contents follow from the chosen first register.

The host's SCL and SDA are sampled with a fast system clock. START and STOP are recognised as SDA edges while SCL is high. The target pulls SDA low through an open-drain enable, and only ever begins pulling it while SCL is low.

The setup is kept across STOP, so a split read uses the last accepted values. Reading does not shift the register pointer back to zero at the top of the space: past the last register the target sends zero bytes for as long as the host keeps acknowledging.

Top module: `smb_blkrd_target`

## Requirements
- R1: The target acknowledges only a first byte whose upper seven bits equal its own address (default 0x2C). Bit 0 of that byte selects the direction: 0 is a write, 1 is a read. Any other address is not acknowledged, and SDA stays released until the next START.
- R2: After an address with the write bit, the command byte 0x F1 (value 0xF1) is acknowledged. Any other command byte is not acknowledged.
- R3: In the setup write, the byte after the command must be 0x02 and is then acknowledged, and any other value is not. The next two bytes, the first register and the length, are always acknowledged. A setup is stored only once its length byte has been received.
- R4: The first byte of every read is the stored length. This holds both after a repeated START that directly follows the setup and in a later transaction of START, write address, 0xF1, repeated START and read address. The setup survives STOP.
- R5: Data bytes follow the length byte, starting at the stored first register and ascending one register per byte. Register a holds (3*a + 0x40) mod 256 when a is in 0x00–0x3F or 0xF0–0xFF, and 0x00 everywhere else.
- R6: After register 0xFF has been sent, every further byte is 0x00. The register index never returns to 0x00.
- R7: The length byte does not limit the stream. The target keeps sending bytes for as long as the host acknowledges them.
- R8: When the host does not acknowledge a byte, whether the length byte or any data byte, the target releases SDA and keeps it released until the next START or STOP.
- R9: A read made before any setup has been accepted since reset returns a length byte of 0x01, with data starting at register 0x00.
- R10: A stored length of 0x00 or above 0x20 becomes 0x20. The length byte is still acknowledged.
- R11: SDA is released out of reset. The target only starts pulling SDA low while SCL is low. A STOP returns the interface to idle, and a START restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | When high, the target pulls SDA low |

## Verification
The assertions watch on every cycle that SDA starts being driven only while SCL is low, that the stored length stays within 1 to 32, and that the register pointer stays parked once it passes 0xFF. They also check that a host NACK releases SDA and parks the engine, and that any index outside the populated windows reads zero. Only the bench's scenarios can show the byte content of a stream: the length prefix, ascending data, zero fill, no wrap and continuation past the length. They also show which bytes are acknowledged, that a setup survives STOP, and the length and first register used before any setup.

// File: rtl/smb_blkrd_pkg.sv
// Package: shared state encoding for the block-read target.
// Assumes: nothing beyond IEEE 1800-2017.
package smb_blkrd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_CNT,
        ST_SADDR,
        ST_LEN,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT
    } smb_state_e;

endpackage

// File: rtl/smb_line_sync.sv
// Module: synchronises SCL/SDA into the clk domain and flags SCL edges,
// START (SDA falls, SCL high) and STOP (SDA rises, SCL high).
// Assumes: clk is several times faster than SCL; lines idle high.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_sr;
    logic [STAGES-1:0] sda_sr;
    logic              scl_p;
    logic              sda_p;

    // Synchroniser chains plus one history flop per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_in};
            sda_sr <= {sda_sr[STAGES-2:0], sda_in};
            scl_p  <= scl_sr[STAGES-1];
            sda_p  <= sda_sr[STAGES-1];
        end
    end

    // Edge and bus-condition decode from the current and previous sample.
    always_comb begin
        scl_s     = scl_sr[STAGES-1];
        sda_s     = sda_sr[STAGES-1];
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/smb_reg_bank.sv
// Module: fixed-content register bank with a combinational read port.
// Two windows are populated; all other indices, including the
// one-past-the-end index (bit 8 set), read as zero.
// Assumes: content is constant and computed from parameters.
module smb_reg_bank #(
    parameter int DEPTH    = 256,
    parameter int LO_LAST  = 8'h3F,
    parameter int HI_FIRST = 8'hF0,
    parameter int STEP     = 3,
    parameter int SEED     = 8'h40,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic [IDX_W:0] rd_idx,
    output logic [7:0]     rd_data
);

    logic [7:0] bank [DEPTH];

    // Build the table: populated windows get a computed value, gaps read zero.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        if (g <= LO_LAST || g >= HI_FIRST) begin : g_pop
            assign bank[g] = 8'((g * STEP + SEED) % 256);
        end else begin : g_gap
            assign bank[g] = 8'h00;
        end
    end

    // Read port: indices at or past the end of the space return zero.
    always_comb begin
        rd_data = rd_idx[IDX_W] ? 8'h00 : bank[rd_idx[IDX_W-1:0]];
    end

endmodule

// File: rtl/smb_blkrd_fsm.sv
// Module: byte-level protocol engine. Receives the address, command and
// setup bytes, acknowledges them, and streams the length byte followed by
// register data while the host acknowledges.
// Assumes: edge/condition pulses from smb_line_sync; reg bank read is
// combinational.
module smb_blkrd_fsm
    import smb_blkrd_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR  = 7'h2C,
    parameter logic [7:0] CMD_CODE  = 8'hF1,
    parameter logic [7:0] SETUP_CNT = 8'h02,
    parameter int         MAX_LEN   = 32,
    localparam int        LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [8:0] rd_idx,
    output logic       sda_oe
);

    localparam logic [8:0] PTR_END = 9'd256;

    smb_state_e       st_q, ack_next_q, rx_next;
    logic [3:0]       bit_cnt_q;
    logic [7:0]       rx_sh_q, tx_sh_q, saddr_tmp_q, start_q;
    logic [LEN_W-1:0] len_q, len_clamped;
    logic [8:0]       ptr_q;
    logic             sda_oe_q, host_ack_q;
    logic             rx_ack, in_rx, byte_done, ptr_load;
    logic [7:0]       tx_first;

    // Accept/next-state decision for a completed received byte.
    always_comb begin
        rx_ack  = 1'b0;
        rx_next = ST_WAIT;
        case (st_q)
            ST_ADDR:  if (rx_sh_q[7:1] == TGT_ADDR) begin
                          rx_ack  = 1'b1;
                          rx_next = rx_sh_q[0] ? ST_TX : ST_CMD;
                      end
            ST_CMD:   if (rx_sh_q == CMD_CODE) begin
                          rx_ack  = 1'b1;
                          rx_next = ST_CNT;
                      end
            ST_CNT:   if (rx_sh_q == SETUP_CNT) begin
                          rx_ack  = 1'b1;
                          rx_next = ST_SADDR;
                      end
            ST_SADDR: begin
                          rx_ack  = 1'b1;
                          rx_next = ST_LEN;
                      end
            ST_LEN:   begin
                          rx_ack  = 1'b1;
                          rx_next = ST_WAIT;
                      end
            default:  ;
        endcase
    end

    // Byte-complete strobe, pointer load, length clamp and count byte.
    always_comb begin
        in_rx       = st_q inside {ST_ADDR, ST_CMD, ST_CNT, ST_SADDR, ST_LEN};
        byte_done   = in_rx && scl_fall && (bit_cnt_q == 4'd8);
        ptr_load    = byte_done && rx_ack && (st_q == ST_ADDR) && rx_sh_q[0];
        len_clamped = (rx_sh_q == 8'h00 || rx_sh_q > 8'(MAX_LEN))
                      ? LEN_W'(MAX_LEN) : rx_sh_q[LEN_W-1:0];
        tx_first    = {{(8 - LEN_W){1'b0}}, len_q};
    end

    // Main protocol sequencer; STOP and START take priority over all states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            ack_next_q  <= ST_IDLE;
            bit_cnt_q   <= '0;
            rx_sh_q     <= '0;
            tx_sh_q     <= '0;
            saddr_tmp_q <= '0;
            start_q     <= 8'h00;
            len_q       <= LEN_W'(1);
            ptr_q       <= '0;
            sda_oe_q    <= 1'b0;
            host_ack_q  <= 1'b0;
        end else if (stop_det) begin
            st_q     <= ST_IDLE;
            sda_oe_q <= 1'b0;
        end else if (start_det) begin
            st_q      <= ST_ADDR;
            bit_cnt_q <= '0;
            sda_oe_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_ADDR, ST_CMD, ST_CNT, ST_SADDR, ST_LEN: begin
                    if (scl_rise && bit_cnt_q != 4'd8) begin
                        rx_sh_q   <= {rx_sh_q[6:0], sda_s};
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                    end
                    if (byte_done) begin
                        bit_cnt_q <= '0;
                        if (rx_ack) begin
                            sda_oe_q   <= 1'b1;
                            ack_next_q <= rx_next;
                            st_q       <= ST_RX_ACK;
                        end else begin
                            st_q <= ST_WAIT;
                        end
                        if (st_q == ST_SADDR) saddr_tmp_q <= rx_sh_q;
                        if (st_q == ST_LEN) begin
                            start_q <= saddr_tmp_q;
                            len_q   <= len_clamped;
                        end
                        if (ptr_load) ptr_q <= {1'b0, start_q};
                    end
                end
                ST_RX_ACK: if (scl_fall) begin
                    st_q      <= ack_next_q;
                    bit_cnt_q <= '0;
                    if (ack_next_q == ST_TX) begin
                        sda_oe_q <= ~tx_first[7];
                        tx_sh_q  <= {tx_first[6:0], 1'b0};
                    end else begin
                        sda_oe_q <= 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) bit_cnt_q <= bit_cnt_q + 4'd1;
                    if (scl_fall) begin
                        if (bit_cnt_q == 4'd8) begin
                            sda_oe_q   <= 1'b0;
                            host_ack_q <= 1'b0;
                            st_q       <= ST_TX_ACK;
                        end else begin
                            sda_oe_q <= ~tx_sh_q[7];
                            tx_sh_q  <= {tx_sh_q[6:0], 1'b0};
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        if (sda_s) st_q <= ST_WAIT;
                        else       host_ack_q <= 1'b1;
                    end
                    if (scl_fall && host_ack_q) begin
                        st_q      <= ST_TX;
                        bit_cnt_q <= '0;
                        sda_oe_q  <= ~rd_data[7];
                        tx_sh_q   <= {rd_data[6:0], 1'b0};
                        ptr_q     <= (ptr_q == PTR_END) ? ptr_q : ptr_q + 9'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign rd_idx = ptr_q;
    assign sda_oe = sda_oe_q;

    // SDA is only newly pulled low while SCL is low.
    assert_drive_low_scl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_q) |-> !scl_s);

    // Stored length always within 1..MAX_LEN.
    assert_len_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q != '0) && (len_q <= LEN_W'(MAX_LEN)));

    // Pointer parks past the top and never wraps unless reloaded.
    assert_ptr_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == PTR_END && !ptr_load) |=> (ptr_q == PTR_END));

    // A host NACK releases SDA and parks the engine.
    assert_nack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TX_ACK && scl_rise && sda_s && !stop_det && !start_det)
        |=> (st_q == ST_WAIT && !sda_oe_q));

endmodule

// File: rtl/smb_blkrd_target.sv
// Module: top of the SMBus block-read target. Ties the line synchroniser,
// protocol engine and register bank together.
// Assumes: external pull-up on SDA; sda_oe high means pull SDA low.
module smb_blkrd_target #(
    parameter logic [6:0] TGT_ADDR = 7'h2C,
    parameter logic [7:0] CMD_CODE = 8'hF1,
    parameter int         MAX_LEN  = 32,
    parameter int         SYNC_STAGES = 2,
    parameter int         LO_LAST  = 8'h3F,
    parameter int         HI_FIRST = 8'hF0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [8:0] rd_idx;
    logic [7:0] rd_data;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_blkrd_fsm #(.TGT_ADDR(TGT_ADDR), .CMD_CODE(CMD_CODE),
                    .SETUP_CNT(8'h02), .MAX_LEN(MAX_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_data(rd_data), .rd_idx(rd_idx), .sda_oe(sda_oe)
    );

    smb_reg_bank #(.DEPTH(256), .LO_LAST(LO_LAST), .HI_FIRST(HI_FIRST),
                   .STEP(3), .SEED(8'h40)) u_bank (
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // Indices outside the populated windows read as zero.
    assert_gap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx[8] || (int'(rd_idx[7:0]) > LO_LAST && int'(rd_idx[7:0]) < HI_FIRST))
        |-> (rd_data == 8'h00));

endmodule

// File: tb/smb_blkrd_target_bench.sv
module smb_blkrd_target_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam logic [6:0] ADDR = 7'h2C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    assign sda_line = sda_h & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_blkrd_target u_smb_blkrd_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_line), .sda_oe(sda_oe)
    );

    function automatic logic [7:0] exp_val(int a);
        if (a > 255) return 8'h00;
        if (a <= 8'h3F || a >= 8'hF0) return 8'((3 * a + 8'h40) % 256);
        return 8'h00;
    endfunction

    task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wait_q(); scl_h = 1'b1; wait_q();
        sda_h = 1'b0; wait_q(); scl_h = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wait_q(); scl_h = 1'b1; wait_q();
        sda_h = 1'b1; wait_q(); wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; wait_q(); scl_h = 1'b1; wait_q(); wait_q();
            scl_h = 1'b0; wait_q();
        end
        sda_h = 1'b1; wait_q(); scl_h = 1'b1; wait_q();
        ack = ~sda_line; wait_q(); scl_h = 1'b0; wait_q();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_h = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wait_q(); scl_h = 1'b1; wait_q();
            b = {b[6:0], sda_line}; wait_q(); scl_h = 1'b0;
        end
        sda_h = give_ack ? 1'b0 : 1'b1;
        wait_q(); scl_h = 1'b1; wait_q(); wait_q(); scl_h = 1'b0; wait_q();
        sda_h = 1'b1;
    endtask

    // Clocks nine bit times with SDA released by the host; counts low samples.
    task automatic watch_release(string req);
        int lows = 0;
        for (int i = 0; i < 9; i++) begin
            wait_q(); scl_h = 1'b1; wait_q();
            if (sda_line == 1'b0) lows++;
            wait_q(); scl_h = 1'b0;
        end
        wait_q();
        check(req, "SDA low samples after NACK", 8'(lows), 8'h00);
    endtask

    task automatic send_exp(string req, logic [7:0] b, logic exp_ack);
        logic ack;
        send_byte(b, ack);
        check(req, "ack bit", {7'b0, ack}, {7'b0, exp_ack});
    endtask

    task automatic setup_write(logic [7:0] sa, logic [7:0] ln);
        bus_start();
        send_exp("R1", {ADDR, 1'b0}, 1'b1);
        send_exp("R2", 8'hF1, 1'b1);
        send_exp("R3", 8'h02, 1'b1);
        send_exp("R3", sa, 1'b1);
        send_exp("R10", ln, 1'b1);
    endtask

    task automatic read_only_open();
        bus_start();
        send_exp("R1", {ADDR, 1'b0}, 1'b1);
        send_exp("R2", 8'hF1, 1'b1);
        bus_start();
        send_exp("R1", {ADDR, 1'b1}, 1'b1);
    endtask

    task automatic read_stream(string req, logic [7:0] exp_cnt, int first, int n);
        logic [7:0] b;
        recv_byte(1'b1, b);
        check("R4", "count byte", b, exp_cnt);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            check(req, $sformatf("data[%0d]", i), b, exp_val(first + i));
        end
        watch_release("R8");
        bus_stop();
    endtask

    task automatic t_reset();
        check("R11", "sda_oe after reset", {7'b0, sda_oe}, 8'h00);
    endtask

    task automatic t_no_setup_r9();
        read_only_open();
        read_stream("R9", 8'h01, 0, 2);
    endtask

    task automatic t_combined_r4();
        setup_write(8'h10, 8'h04);
        bus_start();
        send_exp("R4", {ADDR, 1'b1}, 1'b1);
        read_stream("R5", 8'h04, 8'h10, 4);
    endtask

    task automatic t_split_r5();
        setup_write(8'h3D, 8'h05);
        bus_stop();
        read_only_open();
        read_stream("R5", 8'h05, 8'h3D, 5);
    endtask

    task automatic t_overrun_r7();
        setup_write(8'hEE, 8'h01);
        bus_start();
        send_exp("R7", {ADDR, 1'b1}, 1'b1);
        read_stream("R7", 8'h01, 8'hEE, 6);
    endtask

    task automatic t_nowrap_r6();
        setup_write(8'hFD, 8'h03);
        bus_start();
        send_exp("R6", {ADDR, 1'b1}, 1'b1);
        read_stream("R6", 8'h03, 8'hFD, 5);
    endtask

    task automatic t_clamp_r10();
        setup_write(8'h00, 8'h00);
        bus_start();
        send_exp("R10", {ADDR, 1'b1}, 1'b1);
        read_stream("R10", 8'h20, 0, 1);
        setup_write(8'h20, 8'h45);
        bus_start();
        send_exp("R10", {ADDR, 1'b1}, 1'b1);
        read_stream("R10", 8'h20, 8'h20, 1);
    endtask

    task automatic t_bad_addr_r1();
        bus_start();
        send_exp("R1", {7'h2D, 1'b0}, 1'b0);
        send_exp("R1", 8'hF1, 1'b0);
        bus_stop();
    endtask

    task automatic t_bad_cmd_r2();
        bus_start();
        send_exp("R1", {ADDR, 1'b0}, 1'b1);
        send_exp("R2", 8'h33, 1'b0);
        bus_stop();
    endtask

    task automatic t_bad_count_r3();
        bus_start();
        send_exp("R1", {ADDR, 1'b0}, 1'b1);
        send_exp("R2", 8'hF1, 1'b1);
        send_exp("R3", 8'h03, 1'b0);
        bus_stop();
        read_only_open();
        read_stream("R3", 8'h20, 8'h20, 1);
    endtask

    task automatic t_early_nack_r8();
        logic [7:0] b;
        setup_write(8'h05, 8'h08);
        bus_start();
        send_exp("R8", {ADDR, 1'b1}, 1'b1);
        recv_byte(1'b0, b);
        check("R8", "count byte before NACK", b, 8'h08);
        watch_release("R8");
        bus_stop();
        check("R11", "sda_oe idle after STOP", {7'b0, sda_oe}, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_no_setup_r9();
        t_combined_r4();
        t_split_r5();
        t_overrun_r7();
        t_nowrap_r6();
        t_clamp_r10();
        t_bad_addr_r1();
        t_bad_cmd_r2();
        t_bad_count_r3();
        t_early_nack_r8();
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

endmodule